// File: doc/BRIEF.md
# Pipelined Cell-Array Histogram Engine

This block counts how often each pixel value occurs in a stream. It does this with a chain of identical cells and no RAM. Each cell keeps a small, contiguous group of bin counters in flip-flops. Every clock, up to K pixel samples enter cell 0 together, each with its own lane-valid bit. The samples then move down the chain one cell per clock. A cell adds to its own counters the samples whose value falls in its range. If several lanes hit the same bin in one cycle, that bin grows by the number of hits.

Raising `mode` switches the block to reading. From the first edge at which `mode` is high, new input is ignored. The array first waits as many cycles as it has cells, so that samples already in flight reach their counters. It then turns the whole set of counters into one long shift register that moves toward cell 0. One count leaves per clock, in ascending bin order, with a valid strobe and a bin index, so an external memory can write the counts at sequential addresses. After the last bin the counters are empty. The block returns to counting once `mode` is low again. A synchronous `clr` empties the counters and discards any samples in flight.

Top module: `hist_array`

## Requirements
- R1: After reset, `out_valid` is low and every bin count is zero.
- R2: In counting mode, each input lane whose `in_valid` bit is set adds one to the bin equal to its sample value. Lane l is `in_pix[l*PIX_W +: PIX_W]`. A lane whose valid bit is clear adds nothing.
- R3: When several lanes in one cycle carry the same value, that bin grows by the number of such valid lanes.
- R4: A bin count stops at 2^CNT_W-1 and never wraps.
- R5: When `mode` is first sampled high at edge E, `out_valid` rises after edge E+NCELL (NCELL = 2^PIX_W/BINS_PER_CELL). It then stays high for exactly 2^PIX_W cycles. During those cycles `out_idx` runs 0, 1, 2, … and `out_count` is the count of bin `out_idx`.
- R6: Every sample accepted before the edge at which `mode` is sampled high is included in the counts that are read out.
- R7: Input presented at or after the edge where `mode` is sampled high is ignored until the block is back in counting mode.
- R8: After a readout every bin is zero. Once `mode` has been low for one edge after the readout, the block counts again.
- R9: An edge with `clr` high zeroes every bin and discards both the samples in flight and that cycle's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous bin clear |
| mode | input | 1 | 0 = count, 1 = read out |
| in_valid | input | K | Per-lane sample valid |
| in_pix | input | K*PIX_W | Packed samples, lane l at bits l*PIX_W upward |
| out_valid | output | 1 | Readout count valid |
| out_idx | output | PIX_W | Bin index of the current count |
| out_count | output | CNT_W | Count of bin `out_idx` |

## Verification
The bench aims at the boundaries of the chain.

- It sends samples for the top bin in the very last accepted cycle before `mode` rises. A flush that is too short would drop them.
- It sends identical samples on every lane at once. A design that adds one per cycle instead of one per hit would undercount.
- It holds one bin long enough to pass 2^CNT_W-1, where a wrapping counter would read back small.
- It drives junk on the inputs throughout readout, and right after a `clr`. Leaky gating would show up as extra counts in a later readout.
- It times the readout window edge by edge. An off-by-one in the flush or the shift would move the first index or give the wrong window length.

// File: rtl/hist_pkg.sv
package hist_pkg;

    localparam int DEF_LANES     = 4;
    localparam int DEF_PIX_W     = 6;
    localparam int DEF_BINS_CELL = 4;
    localparam int DEF_CNT_W     = 12;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_FLUSH = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } hist_st_e;

    function automatic int cell_count(input int pix_w, input int bins_cell);
        return (1 << pix_w) / bins_cell;
    endfunction

endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl
    import hist_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int NCELL = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode,
    output hist_st_e         st,
    output logic             accept,
    output logic             shift_en,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_idx
);
    localparam int NBINS = 1 << PIX_W;
    localparam int CW    = PIX_W + 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_COUNT;
            cnt_q <= '0;
        end else begin
            case (st)
                ST_COUNT: begin
                    cnt_q <= '0;
                    if (mode) st <= ST_FLUSH;
                end
                ST_FLUSH: begin
                    if (cnt_q == CW'(NCELL - 1)) begin
                        st    <= ST_SHIFT;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (cnt_q == CW'(NBINS - 1)) begin
                        st    <= ST_DONE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q <= '0;
                    if (!mode) st <= ST_COUNT;
                end
            endcase
        end
    end

    assign accept    = (st == ST_COUNT) && !mode;
    assign shift_en  = (st == ST_SHIFT);
    assign out_valid = shift_en;
    assign out_idx   = cnt_q[PIX_W-1:0];

    // R5: indices step by one through the readout window
    a_r5_idx_step: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_idx == PIX_W'($past(out_idx) + 1'b1)));

    // R5: the window closes only after the top bin
    a_r5_last_idx: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> ($past(out_idx) == PIX_W'(NBINS - 1)));

endmodule

// File: rtl/hist_cell.sv
module hist_cell
    import hist_pkg::*;
#(
    parameter int K         = DEF_LANES,
    parameter int PIX_W     = DEF_PIX_W,
    parameter int BINS_CELL = DEF_BINS_CELL,
    parameter int CNT_W     = DEF_CNT_W,
    parameter int CELL_ID   = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     shift_en,
    input  logic [K+K*PIX_W-1:0]     stg_i,
    output logic [K+K*PIX_W-1:0]     stg_o,
    input  logic [CNT_W-1:0]         shift_in,
    output logic [CNT_W-1:0]         shift_out
);
    localparam int LB = $clog2(BINS_CELL);
    localparam int HB = PIX_W - LB;
    localparam int IW = $clog2(K + 1);
    localparam int SW = K + K * PIX_W;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] bin_q [BINS_CELL];
    logic [IW-1:0]    inc   [BINS_CELL];
    logic [CNT_W-1:0] bin_d [BINS_CELL];

    logic [K-1:0]       lane_v;
    logic [K*PIX_W-1:0] lane_pix;

    assign lane_v   = stg_i[SW-1 -: K];
    assign lane_pix = stg_i[K*PIX_W-1:0];

    // Hit counting: every lane checked against every local bin
    always_comb begin
        for (int j = 0; j < BINS_CELL; j++) begin
            inc[j] = '0;
            for (int l = 0; l < K; l++) begin
                if (lane_v[l]
                    && lane_pix[l*PIX_W + LB +: HB] == HB'(CELL_ID)
                    && lane_pix[l*PIX_W +: LB] == LB'(j))
                    inc[j] = inc[j] + 1'b1;
            end
        end
    end

    // Saturating add per bin
    generate
        for (genvar j = 0; j < BINS_CELL; j++) begin : g_sat
            logic [CNT_W:0] sum;
            assign sum      = {1'b0, bin_q[j]} + (CNT_W+1)'(inc[j]);
            assign bin_d[j] = sum[CNT_W] ? CMAX : sum[CNT_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int j = 0; j < BINS_CELL; j++) bin_q[j] <= '0;
        end else if (shift_en) begin
            for (int j = 0; j < BINS_CELL - 1; j++) bin_q[j] <= bin_q[j+1];
            bin_q[BINS_CELL-1] <= shift_in;
        end else begin
            for (int j = 0; j < BINS_CELL; j++) bin_q[j] <= bin_d[j];
        end
    end

    // Sample pipeline stage toward the next cell
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stg_o <= '0;
        end else if (|lane_v || |stg_o[SW-1 -: K]) begin
            stg_o <= stg_i;
        end
    end

    assign shift_out = bin_q[0];

    generate
        for (genvar j = 0; j < BINS_CELL; j++) begin : g_chk
            // R4: counting never lowers a bin
            a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
                (!$past(shift_en) && !$past(clr)) |-> (bin_q[j] >= $past(bin_q[j])));
            // R3: a bin grows by at most one per lane per cycle
            a_r3_step_bound: assert property (@(posedge clk) disable iff (rst)
                (!$past(shift_en) && !$past(clr))
                |-> (({1'b0, bin_q[j]} - {1'b0, $past(bin_q[j])}) <= (CNT_W+1)'(K)));
            // R9: a clear edge leaves the bin empty
            a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
                $past(clr) |-> (bin_q[j] == '0));
        end
    endgenerate

endmodule

// File: rtl/hist_array.sv
module hist_array
    import hist_pkg::*;
#(
    parameter int K         = DEF_LANES,
    parameter int PIX_W     = DEF_PIX_W,
    parameter int BINS_CELL = DEF_BINS_CELL,
    parameter int CNT_W     = DEF_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 mode,
    input  logic [K-1:0]         in_valid,
    input  logic [K*PIX_W-1:0]   in_pix,
    output logic                 out_valid,
    output logic [PIX_W-1:0]     out_idx,
    output logic [CNT_W-1:0]     out_count
);
    localparam int NCELL = cell_count(PIX_W, BINS_CELL);
    localparam int SW    = K + K * PIX_W;

    hist_st_e         st;
    logic             accept;
    logic             shift_en;
    logic [SW-1:0]    stg [NCELL+1];
    logic [CNT_W-1:0] sh  [NCELL+1];

    hist_ctrl #(.PIX_W(PIX_W), .NCELL(NCELL)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .st        (st),
        .accept    (accept),
        .shift_en  (shift_en),
        .out_valid (out_valid),
        .out_idx   (out_idx)
    );

    assign stg[0]    = {(accept && !clr) ? in_valid : {K{1'b0}}, in_pix};
    assign sh[NCELL] = '0;
    assign out_count = sh[0];

    generate
        for (genvar i = 0; i < NCELL; i++) begin : g_cell
            hist_cell #(
                .K(K), .PIX_W(PIX_W), .BINS_CELL(BINS_CELL),
                .CNT_W(CNT_W), .CELL_ID(i)
            ) u_cell (
                .clk       (clk),
                .rst       (rst),
                .clr       (clr),
                .shift_en  (shift_en),
                .stg_i     (stg[i]),
                .stg_o     (stg[i+1]),
                .shift_in  (sh[i+1]),
                .shift_out (sh[i])
            );
        end

        for (genvar i = 0; i <= NCELL; i++) begin : g_drain
            // R6: the flush has emptied every stage before counts move
            a_r6_drained: assert property (@(posedge clk) disable iff (rst)
                (st == ST_SHIFT) |-> (stg[i][SW-1 -: K] == '0));
        end
    endgenerate

    // R7: nothing travels down the chain while a finished readout waits
    a_r7_tail_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE && $past(st) == ST_DONE && !$past(clr)) |-> $stable(stg[NCELL]));

endmodule

// File: tb/tb_hist_array.sv
module tb_hist_array;
    localparam int K     = 4;
    localparam int PIX_W = 6;
    localparam int BPC   = 4;
    localparam int CNT_W = 12;
    localparam int M     = 1 << PIX_W;
    localparam int NCELL = M / BPC;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               clr = 1'b0;
    logic               mode = 1'b0;
    logic [K-1:0]       in_valid = '0;
    logic [K*PIX_W-1:0] in_pix = '0;
    logic               out_valid;
    logic [PIX_W-1:0]   out_idx;
    logic [CNT_W-1:0]   out_count;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int exp_bin [M];

    hist_array #(.K(K), .PIX_W(PIX_W), .BINS_CELL(BPC), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .clr(clr), .mode(mode),
        .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_idx(out_idx), .out_count(out_count)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic void model_add(input logic [K-1:0] vm, input logic [K*PIX_W-1:0] px);
        for (int l = 0; l < K; l++) begin
            if (vm[l]) begin
                int b;
                b = int'(px[l*PIX_W +: PIX_W]);
                if (exp_bin[b] < CMAX) exp_bin[b] = exp_bin[b] + 1;
            end
        end
    endfunction

    task automatic push(input logic [K-1:0] vm, input logic [K*PIX_W-1:0] px);
        @(negedge clk);
        in_valid = vm;
        in_pix   = px;
        @(posedge clk);
        model_add(vm, px);
    endtask

    task automatic junk();
        in_valid = K'($urandom);
        in_pix   = (K*PIX_W)'($urandom);
    endtask

    task automatic readout(input string req);
        int lat;
        @(negedge clk);
        mode = 1'b1;
        junk();                                  // R7: same-edge input is ignored
        lat = 0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (out_valid || lat > NCELL + 8) break;
            junk();
        end
        check(lat == NCELL + 1, "R5 latency", lat, NCELL + 1);
        for (int n = 0; n < M; n++) begin
            check(out_valid == 1'b1, "R5 valid", int'(out_valid), 1);
            check(int'(out_idx) == n, "R5 index", int'(out_idx), n);
            check(int'(out_count) == exp_bin[n], req, int'(out_count), exp_bin[n]);
            junk();                              // R7: ignored during readout
            @(posedge clk);
            @(negedge clk);
        end
        check(out_valid == 1'b0, "R5 window length", int'(out_valid), 0);
        mode     = 1'b0;
        in_valid = '0;
        @(posedge clk);                          // R8: back to counting
        for (int b = 0; b < M; b++) exp_bin[b] = 0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int b = 0; b < M; b++) exp_bin[b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        // R1: empty histogram after reset
        readout("R1 bin count after reset");

        // R2 R6: random frame with random lane masks
        for (int c = 0; c < 300; c++)
            push(K'($urandom), (K*PIX_W)'($urandom));
        readout("R2 random frame bin");

        // R3: identical samples on all lanes, and partial masks
        for (int c = 0; c < 10; c++) push(4'hF, {4{6'd9}});
        for (int c = 0; c < 7; c++)  push(4'b0101, {4{6'd42}});
        push(4'b1110, {6'd33, 6'd33, 6'd33, 6'd20});
        readout("R3 multi-lane bin");

        // R6: top and bottom bins in the last accepted cycle
        push(4'hF, {6'd63, 6'd0, 6'd63, 6'd62});
        readout("R6 flush bin");

        // R4: saturation at the counter limit
        for (int c = 0; c < 1100; c++) push(4'hF, {6'd5, 6'd5, 6'd5, 6'd5});
        push(4'b0001, {18'd0, 6'd61});
        readout("R4 saturation bin");

        // R9: clear discards counts, in-flight samples and same-cycle input
        for (int c = 0; c < 40; c++)
            push(K'($urandom), (K*PIX_W)'($urandom));
        @(negedge clk);
        clr = 1'b1;
        junk();
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
        in_valid = '0;
        for (int b = 0; b < M; b++) exp_bin[b] = 0;
        push(4'b0010, {12'd0, 6'd17, 6'd0});
        readout("R9 after clear bin");

        // R7 R8: junk driven during the last readout must not appear now
        readout("R8 R7 after readout bin");

        // R8: counting resumes right after a readout
        for (int c = 0; c < 120; c++)
            push(K'($urandom), (K*PIX_W)'($urandom));
        readout("R8 second frame bin");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule